// File: doc/BRIEF.md
# World-ID Access Checker

This block guards one bus target, such as a memory or a peripheral. Every request that reaches it carries a small world identifier. The block checks that identifier and the request address against a set of range rules. A request the rules allow goes to the target, and the target's answer is handed back. A request the rules do not allow never reaches the target. The block answers it locally with all-zero data. Based on a control register, that answer can carry an error flag, raise a sticky interrupt, or both.

Each rule slot holds an inclusive address window, given as a base and a limit. It also holds a permission bitmap with one read bit and one write bit for every world. The rules, the control register and the status-clear register are written through a separate configuration port. That port accepts a write only when the writer presents the trusted world identifier. A status block keeps the address and world of the first denied access until software clears it.

One request is handled at a time. Responses therefore leave in the order their requests arrived.

Top module: `wid_gate`

## Requirements
- R1: An allowed read is forwarded to the target exactly once. The target's read data is returned with the error flag low.
- R2: An allowed write is forwarded to the target exactly once, with its address and write data unchanged.
- R3: A denied read is not forwarded. Its response appears in the cycle after acceptance, and its read data is all zero.
- R4: A denied write is dropped: the target never sees it, and it gets a zero-data response in the cycle after acceptance.
- R5: On a denied response the error flag equals control bit 0. Allowed responses never carry the error flag.
- R6: When control bit 1 is set, a denial sets the interrupt output, and the interrupt stays high until a trusted write to select 25 clears it. If a denial and a clear fall in the same cycle, the interrupt ends up set. After reset the control register holds 2'b11.
- R7: The first denial after reset or after a clear latches its address and world into the fault outputs and raises fault_valid. Later denials leave the fault outputs unchanged until a clear. A denial in the same cycle as a clear is recorded.
- R8: Slot i matches when base <= address <= limit. When several slots match, the lowest-numbered matching slot alone decides.
- R9: An address that matches no slot is denied. After reset all slots hold zero, so every request is denied.
- R10: A configuration write whose world differs from MWID (default 3) changes nothing, neither the rules nor the status.
- R11: In a slot's permission bitmap, bit 2*w is the read permission and bit 2*w+1 is the write permission for world w. Configuration select values are: 0..7 for the bases of slots 0..7, 8..15 for their limits, 16..23 for their permissions, 24 for the control register and 25 for the status clear.
- R12: At most one request is in flight. req_ready is low while a request is in flight. A response is held stable until rsp_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wid | input | WW | World of the requester |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DW | Read data, zero when denied |
| rsp_err | output | 1 | Error flag on a denied response |
| tgt_req_valid | output | 1 | Request to the target |
| tgt_req_ready | input | 1 | Target takes the request |
| tgt_req_write | output | 1 | Target request is a write |
| tgt_req_addr | output | AW | Target address |
| tgt_req_wdata | output | DW | Target write data |
| tgt_rsp_valid | input | 1 | Target answer, one-cycle pulse |
| tgt_rsp_rdata | input | DW | Target read data |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_wid | input | WW | World of the configuration writer |
| cfg_sel | input | SW+2 | Register select |
| cfg_wdata | input | AW | Configuration write data |
| irq | output | 1 | Sticky denial interrupt |
| fault_valid | output | 1 | A denial has been recorded |
| fault_addr | output | AW | Address of the recorded denial |
| fault_wid | output | WW | World of the recorded denial |

## Verification
Two events can collide in one clock edge: a denied request being accepted, and a trusted status clear arriving on the configuration port. The bench drives both at the same falling edge. After the shared rising edge it expects the interrupt to be high again. It also expects fault_valid to be high, with the fault address and world holding the new denial rather than the old one. The rule sweep covers overlapping windows. In those windows the lower slot must override a more permissive higher slot. Each result is compared with a model the bench builds from the rules it programmed.

// File: rtl/wid_gate.sv
module wid_gate #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NWID  = 4,
  parameter int NSLOT = 8,
  parameter int MWID  = 3,
  localparam int WW   = $clog2(NWID),
  localparam int SW   = $clog2(NSLOT),
  localparam int PW   = 2 * NWID
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [WW-1:0] req_wid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          tgt_req_valid,
  input  logic          tgt_req_ready,
  output logic          tgt_req_write,
  output logic [AW-1:0] tgt_req_addr,
  output logic [DW-1:0] tgt_req_wdata,
  input  logic          tgt_rsp_valid,
  input  logic [DW-1:0] tgt_rsp_rdata,
  input  logic          cfg_valid,
  input  logic [WW-1:0] cfg_wid,
  input  logic [SW+1:0] cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          irq,
  output logic          fault_valid,
  output logic [AW-1:0] fault_addr,
  output logic [WW-1:0] fault_wid
);

  typedef enum logic [1:0] {S_IDLE, S_FWD, S_WAIT, S_RSP} state_t;

  state_t        state;
  logic [AW-1:0] base_q [NSLOT];
  logic [AW-1:0] lim_q  [NSLOT];
  logic [PW-1:0] perm_q [NSLOT];
  logic [1:0]    ctrl_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q, rd_q;
  logic          w_q, err_q;

  logic          hit;
  logic [PW-1:0] hit_perm;
  logic [WW:0]   pidx;
  logic          allow, accept, deny_acc;
  logic          cfg_ok, clr;
  logic [1:0]    cfg_kind;
  logic [SW-1:0] cfg_slot;

  always_comb begin
    hit = 1'b0;
    hit_perm = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (req_addr >= base_q[i] && req_addr <= lim_q[i]) begin
        hit = 1'b1;
        hit_perm = perm_q[i];
      end
  end

  assign pidx     = {req_wid, req_write};
  assign allow    = hit && hit_perm[pidx];
  assign accept   = req_valid && req_ready;
  assign deny_acc = accept && !allow;

  assign cfg_ok   = cfg_valid && (cfg_wid == WW'(MWID));
  assign cfg_kind = cfg_sel[SW+1:SW];
  assign cfg_slot = cfg_sel[SW-1:0];
  assign clr      = cfg_ok && cfg_kind == 2'd3 && cfg_slot == SW'(1);

  assign req_ready     = state == S_IDLE;
  assign tgt_req_valid = state == S_FWD;
  assign tgt_req_write = w_q;
  assign tgt_req_addr  = a_q;
  assign tgt_req_wdata = d_q;
  assign rsp_valid     = state == S_RSP;
  assign rsp_rdata     = rd_q;
  assign rsp_err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        perm_q[i] <= '0;
      end
      ctrl_q <= 2'b11;
    end else if (cfg_ok) begin
      case (cfg_kind)
        2'd0: base_q[cfg_slot] <= cfg_wdata;
        2'd1: lim_q[cfg_slot]  <= cfg_wdata;
        2'd2: perm_q[cfg_slot] <= cfg_wdata[PW-1:0];
        default: if (cfg_slot == '0) ctrl_q <= cfg_wdata[1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      a_q   <= '0;
      d_q   <= '0;
      w_q   <= 1'b0;
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          a_q <= req_addr;
          d_q <= req_wdata;
          w_q <= req_write;
          rd_q <= '0;
          err_q <= !allow && ctrl_q[0];
          state <= allow ? S_FWD : S_RSP;
        end
        S_FWD: if (tgt_req_ready) state <= S_WAIT;
        S_WAIT: if (tgt_rsp_valid) begin
          rd_q <= tgt_rsp_rdata;
          state <= S_RSP;
        end
        default: if (rsp_ready) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq         <= 1'b0;
      fault_valid <= 1'b0;
      fault_addr  <= '0;
      fault_wid   <= '0;
    end else begin
      if (deny_acc && ctrl_q[1]) irq <= 1'b1;
      else if (clr)              irq <= 1'b0;
      if (deny_acc)   fault_valid <= 1'b1;
      else if (clr)   fault_valid <= 1'b0;
      if (deny_acc && (!fault_valid || clr)) begin
        fault_addr <= req_addr;
        fault_wid  <= req_wid;
      end
    end
  end

endmodule

module wid_gate_props #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int WW   = 2,
  parameter int SW   = 3,
  parameter int MWID = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic          tgt_req_valid,
  input logic          tgt_req_ready,
  input logic [AW-1:0] tgt_req_addr,
  input logic          cfg_valid,
  input logic [WW-1:0] cfg_wid,
  input logic [SW+1:0] cfg_sel,
  input logic          irq,
  input logic          fault_valid,
  input logic [AW-1:0] fault_addr,
  input logic [WW-1:0] fault_wid,
  input logic          deny
);
  logic clr_p;
  assign clr_p = cfg_valid && cfg_wid == WW'(MWID) && cfg_sel == {2'b11, SW'(1)};

  assert_deny_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    deny |=> rsp_valid && rsp_rdata == '0 && !tgt_req_valid);

  assert_single_flight_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, tgt_req_valid, rsp_valid}));

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  assert_tgt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req_valid && !tgt_req_ready |=> tgt_req_valid && $stable(tgt_req_addr));

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_p |=> irq);

  assert_fault_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !clr_p |=> fault_valid && $stable(fault_addr) && $stable(fault_wid));

  assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == '0);
endmodule

bind wid_gate wid_gate_props #(.AW(AW), .DW(DW), .WW(WW), .SW(SW), .MWID(MWID)) u_props (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
  .tgt_req_valid(tgt_req_valid), .tgt_req_ready(tgt_req_ready),
  .tgt_req_addr(tgt_req_addr), .cfg_valid(cfg_valid), .cfg_wid(cfg_wid),
  .cfg_sel(cfg_sel), .irq(irq), .fault_valid(fault_valid),
  .fault_addr(fault_addr), .fault_wid(fault_wid), .deny(deny_acc)
);

// File: tb/wid_gate_test.sv
module wid_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [1:0]  req_wid = 0;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        tgt_req_valid, tgt_req_write;
  logic        tgt_req_ready = 1;
  logic [15:0] tgt_req_addr;
  logic [31:0] tgt_req_wdata;
  logic        tgt_rsp_valid;
  logic [31:0] tgt_rsp_rdata;
  logic        cfg_valid = 0;
  logic [1:0]  cfg_wid = 0;
  logic [4:0]  cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic        irq, fault_valid;
  logic [15:0] fault_addr;
  logic [1:0]  fault_wid;

  wid_gate uut (.*);

  int          checks = 0, errors = 0, tgt_hits = 0;
  bit          done = 0;
  logic [15:0] last_waddr;
  logic [31:0] last_wdata;
  logic [15:0] mb [8], ml [8];
  logic [7:0]  mp [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      tgt_rsp_valid <= 1'b0;
      tgt_rsp_rdata <= '0;
    end else begin
      tgt_rsp_valid <= tgt_req_valid && tgt_req_ready;
      tgt_rsp_rdata <= {16'hC0DE, tgt_req_addr};
      if (tgt_req_valid && tgt_req_ready) begin
        tgt_hits <= tgt_hits + 1;
        if (tgt_req_write) begin
          last_waddr <= tgt_req_addr;
          last_wdata <= tgt_req_wdata;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model_allow(input logic [1:0] w, input logic wr, input logic [15:0] a);
    for (int i = 0; i < 8; i++)
      if (a >= mb[i] && a <= ml[i]) return mp[i][2 * w + (wr ? 1 : 0)];
    return 1'b0;
  endfunction

  task automatic cfg_wr(input logic [1:0] w, input logic [4:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_valid = 1; cfg_wid = w; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic set_rule(input int i, input logic [15:0] b, input logic [15:0] l, input logic [7:0] p);
    cfg_wr(2'd3, 5'(i), b);
    cfg_wr(2'd3, 5'(8 + i), l);
    cfg_wr(2'd3, 5'(16 + i), {8'h0, p});
    mb[i] = b; ml[i] = l; mp[i] = p;
  endtask

  task automatic xfer(input logic wr, input logic [1:0] w, input logic [15:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output logic e, output bit fwd, output int lat);
    int n0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_wid = w; req_addr = a; req_wdata = wd;
    n0 = tgt_hits;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata; e = rsp_err;
    @(negedge clk);
    fwd = tgt_hits != n0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic e;
    bit fwd, al;
    int lat;
    logic [31:0] wd;
    for (int i = 0; i < 8; i++) begin mb[i] = 0; ml[i] = 0; mp[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !tgt_req_valid, "R12 reset idle", {req_ready, rsp_valid, tgt_req_valid}, 3'b100);
    chk(!irq && !fault_valid, "R6 R7 reset status", {irq, fault_valid}, 0);

    xfer(1'b0, 2'd3, 16'h0010, 0, rd, e, fwd, lat);
    chk(!fwd && rd == 0, "R9 reset rules deny", {fwd, rd}, 0);
    chk(e == 1'b1 && irq == 1'b1, "R6 reset control both on", {e, irq}, 2'b11);
    cfg_wr(2'd3, 5'd25, 0);
    chk(!irq && !fault_valid, "R6 trusted clear", {irq, fault_valid}, 0);

    set_rule(0, 16'h0010, 16'h001F, 8'h0D);
    set_rule(1, 16'h0018, 16'h002F, 8'hFF);
    set_rule(2, 16'h0040, 16'h0040, 8'h80);
    cfg_wr(2'd3, 5'd24, 16'h0001);

    for (int a = 0; a < 16'h50; a++)
      for (int w = 0; w < 4; w++)
        for (int op = 0; op < 2; op++) begin
          wd = {16'(a), 8'(w), 8'h5A};
          al = model_allow(2'(w), op[0], 16'(a));
          xfer(op[0], 2'(w), 16'(a), wd, rd, e, fwd, lat);
          chk(fwd == al, "R8 R9 R11 decision", fwd, al);
          chk(e == !al, "R5 error flag", e, !al);
          if (!al) begin
            chk(rd == 0 && lat == 1, op[0] ? "R4 denied write dropped" : "R3 denied read zero", {rd, 8'(lat)}, 1);
          end else if (op == 0) begin
            chk(rd == {16'hC0DE, 16'(a)}, "R1 allowed read data", rd, {16'hC0DE, 16'(a)});
          end else begin
            chk(last_waddr == 16'(a) && last_wdata == wd, "R2 allowed write", {last_waddr, last_wdata}, {16'(a), wd});
          end
        end
    chk(!irq, "R6 no irq when disabled", irq, 0);

    cfg_wr(2'd3, 5'd25, 0);
    cfg_wr(2'd3, 5'd24, 16'h0002);
    xfer(1'b0, 2'd2, 16'h0005, 0, rd, e, fwd, lat);
    chk(!e && rd == 0, "R5 error flag off", {e, rd}, 0);
    chk(irq, "R6 irq raised", irq, 1);
    chk(fault_valid && fault_addr == 16'h0005 && fault_wid == 2'd2, "R7 first fault", {fault_valid, fault_addr, fault_wid}, {1'b1, 16'h0005, 2'd2});
    xfer(1'b1, 2'd1, 16'h0030, 0, rd, e, fwd, lat);
    chk(!fwd, "R4 denied write", fwd, 0);
    chk(fault_addr == 16'h0005 && fault_wid == 2'd2, "R7 fault kept", {fault_addr, fault_wid}, {16'h0005, 2'd2});

    cfg_wr(2'd1, 5'd25, 0);
    chk(irq && fault_valid, "R10 untrusted clear ignored", {irq, fault_valid}, 2'b11);
    cfg_wr(2'd0, 5'd18, 16'h00FF);
    xfer(1'b0, 2'd3, 16'h0040, 0, rd, e, fwd, lat);
    chk(!fwd && rd == 0, "R10 untrusted rule write ignored", fwd, 0);
    xfer(1'b1, 2'd3, 16'h0040, 32'h1234, rd, e, fwd, lat);
    chk(fwd && last_wdata == 32'h1234, "R11 write-only permission", fwd, 1);

    cfg_wr(2'd3, 5'd25, 0);
    chk(!irq && !fault_valid, "R6 clear", {irq, fault_valid}, 0);
    xfer(1'b0, 2'd1, 16'h0011, 0, rd, e, fwd, lat);
    chk(!fault_valid && !irq, "R7 allowed leaves status", {irq, fault_valid}, 0);

    cfg_wr(2'd3, 5'd25, 0);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_wid = 2'd0; req_addr = 16'h0060;
    cfg_valid = 1; cfg_wid = 2'd3; cfg_sel = 5'd25;
    @(negedge clk);
    req_valid = 0; cfg_valid = 0;
    chk(rsp_valid && rsp_rdata == 0, "R3 deny one cycle", {rsp_valid, rsp_rdata}, 33'h100000000);
    chk(irq, "R6 set beats clear", irq, 1);
    chk(fault_valid && fault_addr == 16'h0060 && fault_wid == 2'd0, "R7 recorded on clear", {fault_valid, fault_addr}, {1'b1, 16'h0060});
    @(negedge clk);

    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_wid = 2'd1; req_addr = 16'h0012; req_write = 0;
    @(negedge clk);
    req_valid = 0;
    repeat (4) @(negedge clk);
    chk(rsp_valid && !req_ready && rsp_rdata == 32'hC0DE0012, "R12 response held", {rsp_valid, req_ready, rsp_rdata}, {2'b10, 32'hC0DE0012});
    rsp_ready = 1;
    @(negedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R12 back to idle", {req_ready, rsp_valid}, 2'b10);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule